// File: doc/BRIEF.md
# Input Reference Clock Selector

This block decides which of four reference clocks is handed to a downstream PLL, and watches every reference for loss of signal. It sits in a fast system clock domain. Each reference arrives as a single-cycle strobe that has already been synchronized: one strobe for each edge of that reference. A two-bit mode input chooses manual selection, automatic non-revertive switching or automatic revertive switching. A two-bit manual select names the wanted reference when the mode is manual.

Each reference has its own silence watchdog and its own sticky alarm. The alarm clears only after the reference has run cleanly for a set number of trigger windows. The automatic modes use a fixed priority, with index 0 highest. When the chosen reference is unusable, holdover tells the PLL to freeze its frequency. In automatic modes that happens when every reference is in alarm; in manual mode it happens when the selected reference is in alarm. The manual select passes through a deglitcher, so a short pulse on it never moves the selection.

Top module: `refclk_selector`

## Requirements
- R1: While reset is held and on the first cycle after it, sel_idx is 0, every ref_alarm bit is 0, holdover is 0 and active_oh is 4'b0001.
- R2: ref_alarm[i] rises after WIN_CYC consecutive system-clock samples with ref_edge[i] low.
- R3: Once set, ref_alarm[i] stays high until reference i has gone REVAL_WINS*WIN_CYC consecutive samples without another WIN_CYC-long silence, counted from its first returning strobe. Only then does it fall.
- R4: In manual mode (mode 2'b00), sel_idx follows the deglitched manual select: 00 picks reference index 0, 01 index 1, 10 index 2 and 11 index 3. active_oh is all zero in this mode.
- R5: A new manual select value is applied only after it has been sampled unchanged for DEGLITCH consecutive system clocks. A shorter excursion leaves sel_idx unchanged.
- R6: Mode encoding is 2'b00 manual, 2'b01 automatic non-revertive and 2'b10 automatic revertive. The code 2'b11, which an undriven or floating setting resolves to, behaves as automatic non-revertive.
- R7: In non-revertive mode the selection changes only when the selected reference is in alarm. It then moves to the lowest-index reference that is not in alarm.
- R8: In revertive mode the selection is always the lowest-index reference that is not in alarm, so it returns to a higher-priority reference as soon as that reference revalidates.
- R9: In the automatic modes active_oh is the one-hot form of sel_idx, where bit i means reference index i, and the two change in the same cycle.
- R10: holdover is high one cycle after every reference is in alarm, or in manual mode one cycle after the selected reference is in alarm. It falls as soon as the reference selected under the current mode rules is valid. With all references lost, the selection is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_edge | input | 4 | Synchronized one-cycle edge strobe per reference |
| mode | input | 2 | Selection mode (see R6) |
| man_sel | input | 2 | Manual reference select |
| sel_idx | output | 2 | Index of the reference fed to the PLL |
| active_oh | output | 4 | One-hot active indicator (automatic modes) |
| ref_alarm | output | 4 | Sticky loss-of-signal alarm per reference |
| holdover | output | 1 | Freeze request to the PLL |

## Verification
The assertions assume that ref_edge is already synchronous to clk and that each strobe lasts one sample. They also assume that mode and man_sel change only between clock edges. The bench drives all of these on the falling edge. Each running reference toggles at a period well below WIN_CYC, so a live reference never trips its watchdog by accident. Silence comes only from switching a reference off on purpose for longer than a window, so every alarm in a run is intended. Manual select pulses shorter than DEGLITCH are used to show that they are rejected.

// File: rtl/refsel_pkg.sv
package refsel_pkg;
  localparam int NREF = 4;
  localparam int IDX_W = 2;

  typedef enum logic [1:0] {
    MODE_MANUAL   = 2'b00,
    MODE_AUTO_NR  = 2'b01,
    MODE_AUTO_REV = 2'b10,
    MODE_FLOAT    = 2'b11
  } refsel_mode_e;

  // lowest index whose alarm is clear (0 when none)
  function automatic logic [IDX_W-1:0] first_valid(input logic [NREF-1:0] alarm);
    logic [IDX_W-1:0] idx;
    idx = '0;
    for (int i = NREF - 1; i >= 0; i--) begin
      if (!alarm[i]) idx = IDX_W'(i);
    end
    return idx;
  endfunction

  function automatic logic is_auto(input logic [1:0] m);
    return m != MODE_MANUAL;
  endfunction

  function automatic logic [NREF-1:0] to_onehot(input logic [IDX_W-1:0] idx);
    return NREF'(1) << idx;
  endfunction
endpackage

// File: rtl/refsel_los_mon.sv
module refsel_los_mon #(
  parameter int WIN_CYC    = 48,
  parameter int REVAL_WINS = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic edge_i,
  output logic alarm_o,
  output logic miss_o
);
  localparam int GAP_W  = $clog2(WIN_CYC) + 1;
  localparam int OK_TGT = REVAL_WINS * WIN_CYC;
  localparam int OK_W   = $clog2(OK_TGT) + 1;

  logic [GAP_W-1:0] gap_q;
  logic [OK_W-1:0]  ok_q;
  logic             alarm_q;
  logic             reval_done;

  // a silent sample arriving when the gap already spans a window minus one
  assign miss_o     = !edge_i && (gap_q == GAP_W'(WIN_CYC - 1));
  assign reval_done = alarm_q && !miss_o && (ok_q == OK_W'(OK_TGT - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q   <= '0;
      ok_q    <= '0;
      alarm_q <= 1'b0;
    end else begin
      if (edge_i)                            gap_q <= '0;
      else if (gap_q != GAP_W'(WIN_CYC - 1)) gap_q <= gap_q + 1'b1;

      if (miss_o) begin
        alarm_q <= 1'b1;
        ok_q    <= '0;
      end else if (reval_done) begin
        alarm_q <= 1'b0;
        ok_q    <= '0;
      end else if (alarm_q) begin
        ok_q    <= ok_q + 1'b1;
      end
    end
  end

  assign alarm_o = alarm_q;
endmodule

// File: rtl/refsel_deglitch.sv
module refsel_deglitch #(
  parameter int W        = 2,
  parameter int DEGLITCH = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] raw_i,
  output logic [W-1:0] val_o,
  output logic         commit_o
);
  localparam int CNT_W = $clog2(DEGLITCH) + 1;

  logic [W-1:0]     cand_q;
  logic [W-1:0]     val_q;
  logic [CNT_W-1:0] cnt_q;

  assign commit_o = (raw_i == cand_q) && (cnt_q == CNT_W'(DEGLITCH - 2));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cand_q <= '0;
      val_q  <= '0;
      cnt_q  <= '0;
    end else if (raw_i != cand_q) begin
      cand_q <= raw_i;
      cnt_q  <= '0;
    end else begin
      if (cnt_q != CNT_W'(DEGLITCH - 1)) cnt_q <= cnt_q + 1'b1;
      if (commit_o) val_q <= cand_q;
    end
  end

  assign val_o = val_q;
endmodule

// File: rtl/refsel_arbiter.sv
module refsel_arbiter
  import refsel_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       mode_i,
  input  logic [IDX_W-1:0] man_sel_i,
  input  logic [NREF-1:0]  alarm_i,
  output logic [IDX_W-1:0] sel_o,
  output logic [NREF-1:0]  act_o,
  output logic             hold_o,
  output logic             switch_o
);
  logic [IDX_W-1:0] sel_q, nxt;
  logic [NREF-1:0]  act_q;
  logic             hold_q, any_valid;
  logic [IDX_W-1:0] best;

  always_comb begin
    any_valid = ~&alarm_i;
    best      = first_valid(alarm_i);
    nxt       = sel_q;
    case (mode_i)
      MODE_MANUAL:   nxt = man_sel_i;
      MODE_AUTO_REV: if (any_valid) nxt = best;
      default:       if (alarm_i[sel_q] && any_valid) nxt = best;
    endcase
  end

  assign switch_o = nxt != sel_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q  <= '0;
      act_q  <= NREF'(1);
      hold_q <= 1'b0;
    end else begin
      sel_q  <= nxt;
      hold_q <= alarm_i[nxt];
      act_q  <= is_auto(mode_i) ? to_onehot(nxt) : '0;
    end
  end

  assign sel_o  = sel_q;
  assign act_o  = act_q;
  assign hold_o = hold_q;
endmodule

// File: rtl/refclk_selector.sv
module refclk_selector
  import refsel_pkg::*;
#(
  parameter int WIN_CYC    = 48,
  parameter int REVAL_WINS = 2,
  parameter int DEGLITCH   = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NREF-1:0]  ref_edge,
  input  logic [1:0]       mode,
  input  logic [IDX_W-1:0] man_sel,
  output logic [IDX_W-1:0] sel_idx,
  output logic [NREF-1:0]  active_oh,
  output logic [NREF-1:0]  ref_alarm,
  output logic             holdover
);
  // named internal events, visible to the bound checker
  logic [NREF-1:0]  miss_evt;
  logic [IDX_W-1:0] man_sel_q;
  logic             man_commit;
  logic             sel_switch;

  for (genvar g = 0; g < NREF; g++) begin : g_mon
    refsel_los_mon #(
      .WIN_CYC   (WIN_CYC),
      .REVAL_WINS(REVAL_WINS)
    ) u_mon (
      .clk    (clk),
      .rst_n  (rst_n),
      .edge_i (ref_edge[g]),
      .alarm_o(ref_alarm[g]),
      .miss_o (miss_evt[g])
    );
  end

  refsel_deglitch #(
    .W       (IDX_W),
    .DEGLITCH(DEGLITCH)
  ) u_dg (
    .clk     (clk),
    .rst_n   (rst_n),
    .raw_i   (man_sel),
    .val_o   (man_sel_q),
    .commit_o(man_commit)
  );

  refsel_arbiter u_arb (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode_i   (mode),
    .man_sel_i(man_sel_q),
    .alarm_i  (ref_alarm),
    .sel_o    (sel_idx),
    .act_o    (active_oh),
    .hold_o   (holdover),
    .switch_o (sel_switch)
  );
endmodule

// File: rtl/refsel_chk.sv
module refsel_chk
  import refsel_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic [NREF-1:0]  ref_edge,
  input logic [1:0]       mode,
  input logic [IDX_W-1:0] man_sel_q,
  input logic [IDX_W-1:0] sel_idx,
  input logic [NREF-1:0]  active_oh,
  input logic [NREF-1:0]  ref_alarm,
  input logic             holdover
);
  for (genvar g = 0; g < NREF; g++) begin : g_a
    a_r2_rise_on_silence: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ref_alarm[g]) |-> !$past(ref_edge[g]));
  end

  a_r9_active_matches_sel: assert property (@(posedge clk) disable iff (!rst_n)
    (active_oh != '0) |-> ($onehot(active_oh) && active_oh[sel_idx]));

  a_r4_manual_dark: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_MANUAL) |=> (active_oh == '0));

  a_r4_manual_follow: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_MANUAL) |=> (sel_idx == $past(man_sel_q)));

  a_r10_all_lost: assert property (@(posedge clk) disable iff (!rst_n)
    (&ref_alarm) |=> holdover);

  a_r10_manual_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_MANUAL) |=> (holdover == $past(ref_alarm[man_sel_q])));

  a_r7_nonrev_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode == MODE_AUTO_NR || mode == MODE_FLOAT) && !ref_alarm[sel_idx])
      |=> $stable(sel_idx));
endmodule

bind refclk_selector refsel_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .ref_edge (ref_edge),
  .mode     (mode),
  .man_sel_q(man_sel_q),
  .sel_idx  (sel_idx),
  .active_oh(active_oh),
  .ref_alarm(ref_alarm),
  .holdover (holdover)
);

// File: tb/refclk_selector_tb.sv
module refclk_selector_tb;
  localparam int WIN = 48;
  localparam int RV  = 2;
  localparam int DG  = 16;

  logic       clk = 0;
  logic       rst_n = 0;
  logic [3:0] ref_edge = '0;
  logic [1:0] mode = 2'b11;
  logic [1:0] man_sel = '0;
  logic [1:0] sel_idx;
  logic [3:0] active_oh, ref_alarm;
  logic       holdover;

  refclk_selector #(.WIN_CYC(WIN), .REVAL_WINS(RV), .DEGLITCH(DG)) u_dut (
    .clk(clk), .rst_n(rst_n), .ref_edge(ref_edge), .mode(mode), .man_sel(man_sel),
    .sel_idx(sel_idx), .active_oh(active_oh), .ref_alarm(ref_alarm), .holdover(holdover));

  always #10 clk = ~clk;

  int checks = 0, fails = 0, cyc = 0;
  bit en [4] = '{1, 1, 1, 1};
  int per [4] = '{5, 7, 9, 11};
  int ph [4] = '{0, 0, 0, 0};

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  // strobe generators, driven away from the active edge
  always @(negedge clk) begin
    for (int i = 0; i < 4; i++) begin
      ref_edge[i] <= en[i] && (ph[i] == 0);
      ph[i] = (ph[i] + 1) % per[i];
    end
  end

  // behavioural reference model
  int quiet [4], good [4];
  bit [3:0] m_alarm;
  int m_sel, m_act, m_cand, m_cnt, m_man;
  bit m_hold;

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) begin quiet[i] = 0; good[i] = 0; end
      m_alarm = '0; m_sel = 0; m_act = 1; m_hold = 0;
      m_cand = 0; m_cnt = 0; m_man = 0;
    end else begin
      int nxt, best;
      bit any;
      any = 0; best = 0;
      for (int i = 3; i >= 0; i--) if (!m_alarm[i]) begin any = 1; best = i; end
      nxt = m_sel;
      if (mode == 2'b00) nxt = m_man;
      else if (mode == 2'b10) begin if (any) nxt = best; end
      else if (m_alarm[m_sel] && any) nxt = best;
      m_hold = m_alarm[nxt];
      m_act  = (mode != 2'b00) ? (1 << nxt) : 0;
      m_sel  = nxt;
      if (int'(man_sel) != m_cand) begin m_cand = man_sel; m_cnt = 0; end
      else if (m_cnt < DG - 1) begin
        m_cnt++;
        if (m_cnt == DG - 1) m_man = m_cand;
      end
      for (int i = 0; i < 4; i++) begin
        if (ref_edge[i]) quiet[i] = 0;
        else if (quiet[i] < WIN) quiet[i]++;
        if (quiet[i] == WIN) begin m_alarm[i] = 1; good[i] = 0; end
        else if (m_alarm[i]) begin
          good[i]++;
          if (good[i] == RV * WIN) begin m_alarm[i] = 0; good[i] = 0; end
        end
      end
    end
  end

  // cycle-by-cycle comparison
  always @(negedge clk) begin
    if (rst_n) begin
      chk(int'(sel_idx) == m_sel, (mode == 2'b00) ? "R4" : (mode == 2'b10) ? "R8" : "R7",
          sel_idx, m_sel);
      for (int i = 0; i < 4; i++)
        chk(ref_alarm[i] == m_alarm[i], m_alarm[i] ? "R2" : "R3", ref_alarm[i], m_alarm[i]);
      chk(holdover == m_hold, "R10", holdover, m_hold);
      chk(int'(active_oh) == m_act, "R9", active_oh, m_act);
    end
  end

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    wait_n(4);
    chk(sel_idx == 0 && ref_alarm == 0 && !holdover && active_oh == 4'b0001, "R1",
        {sel_idx, ref_alarm, holdover, active_oh}, 11'b00000000001);
    rst_n = 1;
    wait_n(1);
    chk(sel_idx == 0 && active_oh == 4'b0001, "R1", active_oh, 1);
    wait_n(200);
    // mode 2'b11 behaves as non-revertive
    en[0] = 0; wait_n(90);
    chk(ref_alarm[0] == 1, "R2", ref_alarm[0], 1);
    chk(sel_idx == 1, "R6", sel_idx, 1);
    en[0] = 1; wait_n(40);
    chk(ref_alarm[0] == 1, "R3", ref_alarm[0], 1);
    wait_n(100);
    chk(ref_alarm[0] == 0, "R3", ref_alarm[0], 0);
    chk(sel_idx == 1, "R7", sel_idx, 1);
    mode = 2'b01; wait_n(20);
    chk(sel_idx == 1, "R7", sel_idx, 1);
    mode = 2'b10; wait_n(3);
    chk(sel_idx == 0, "R8", sel_idx, 0);
    en[0] = 0; en[1] = 0; wait_n(90);
    chk(sel_idx == 2, "R8", sel_idx, 2);
    en[1] = 1; wait_n(140);
    chk(sel_idx == 1 && active_oh == 4'b0010, "R8", sel_idx, 1);
    en[1] = 0; en[2] = 0; en[3] = 0; wait_n(100);
    chk(holdover == 1 && sel_idx == 1, "R10", holdover, 1);
    en[3] = 1; wait_n(140);
    chk(holdover == 0 && sel_idx == 3, "R10", sel_idx, 3);
    en[0] = 1; en[1] = 1; en[2] = 1; mode = 2'b01; wait_n(160);
    chk(sel_idx == 3, "R7", sel_idx, 3);
    mode = 2'b00; man_sel = 2'b10; wait_n(10);
    chk(sel_idx == 0, "R5", sel_idx, 0);
    wait_n(12);
    chk(sel_idx == 2 && active_oh == 0, "R4", sel_idx, 2);
    man_sel = 2'b01; wait_n(5); man_sel = 2'b10; wait_n(30);
    chk(sel_idx == 2, "R5", sel_idx, 2);
    en[2] = 0; wait_n(80);
    chk(holdover == 1 && sel_idx == 2, "R10", holdover, 1);
    en[2] = 1; wait_n(140);
    chk(holdover == 0, "R10", holdover, 0);
    man_sel = 2'b11; wait_n(25);
    chk(sel_idx == 3, "R4", sel_idx, 3);
    man_sel = 2'b00; wait_n(25);
    chk(sel_idx == 0, "R4", sel_idx, 0);
    man_sel = 2'b01; wait_n(25);
    chk(sel_idx == 1, "R4", sel_idx, 1);
    mode = 2'b10; wait_n(5);
    chk(active_oh == 4'b0001, "R9", active_oh, 1);
    wait_n(20);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule